// File: doc/BRIEF.md
# Run/Stop/Single-Step Clock-Enable Controller

This block decides, cycle by cycle, whether the clocks of a multi-phase processor are enabled while a debugger drives it through a control register. The debugger supplies four level controls: a run request, a step request, a stop-clear strobe and a half-step mode bit. The processor supplies an error line and a power-good line. The block holds a synchronised Run flop and a sticky Stop flop. From these it produces the clock enable, a stopped status, an unclean-halt flag and the half-step mode actually in force.

Instructions take a variable number of phases. Here the processor is represented by a phase counter that advances on every enabled cycle. The counter wraps at the instruction length, which is presented on `instr_len` at phase 0 and held for the rest of the instruction. A halt for a step or an error takes effect only after the last phase, so multi-phase instructions are stepped as a whole. In half-step mode a two-phase instruction also halts after its first phase.

Stop is sticky. After any halt, the run request has no effect until the stop-clear strobe is given. The strobe is accepted only once the run request has been low through the whole synchroniser, so it must arrive in a later write than the one that dropped the run request. This ordering keeps a halt that races with a step command from turning into an extra instruction.

Top module: `runstop_ctrl`

## Requirements
- R1: After reset, `clk_en`, `stopped`, `unclean_halt` and `half_mode` are 0 and `phase` is 0.
- R2: `set_run` passes through a 2-stage synchroniser to give Run. `clk_en` is Run AND NOT Stop, so it goes high 2 clock edges after `set_run` rises while Stop is clear.
- R3: With `set_run` high and `set_ss` and `err` low, `clk_en` stays high and `phase` counts 0,1,...,L-1,0, where L is `instr_len`.
- R4: Stop is set at the end of an enabled cycle in the last phase (phase = L-1, or phase 0 when L is 0 or 1) if `set_ss` or `err` is high. A clean halt therefore leaves `phase` at 0.
- R5: With Stop clear and `set_run` and `set_ss` both high, exactly L enabled cycles occur and the block then halts, even though `set_run` stays high.
- R6: Once Stop is set, it stays set whatever `set_run` does. `clr_stop` clears it only when every synchroniser stage is 0. A `clr_stop` given in the same write that drops `set_run`, or while `set_run` is high, is ignored.
- R7: In half-step mode (`half_mode` = 1) a step with L = 2 halts after phase 0 (1 enabled cycle, `phase` reads 1), and the next step halts after phase 1. For L > 2 there is no intermediate halt.
- R8: `half_mode` copies `half_step` only on cycles where `phase` is 0. A change made while `phase` is not 0 is held until the counter returns to 0.
- R9: An error halts free running at the next instruction boundary. A step with `err` high still executes exactly one whole instruction.
- R10: `stopped` is high combinationally while `power_ok` is low. Power loss sets Stop, so `clk_en` is low from the next cycle, and Stop stays set after power returns until it is cleared.
- R11: If Run falls while Stop is clear and `phase` is not 0, `unclean_halt` is set one cycle later. It is cleared when Run rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_run | input | 1 | Run request level from the control register |
| set_ss | input | 1 | Step request: halt at the next instruction end |
| clr_stop | input | 1 | Stop-clear strobe level |
| half_step | input | 1 | Requested half-step mode |
| err | input | 1 | Processor error indication |
| power_ok | input | 1 | Power good; low means power lost |
| instr_len | input | 4 | Phase count of the instruction starting at phase 0 |
| clk_en | output | 1 | Processor clock enable |
| stopped | output | 1 | Stop flop OR power loss |
| unclean_halt | output | 1 | Run was dropped in mid-instruction |
| half_mode | output | 1 | Half-step mode in force |
| phase | output | 4 | Current phase within the instruction |

## Verification
The results arrive at different times. `clk_en` rises on the second edge after `set_run`. `phase`, Stop and `half_mode` settle on the edge after the enabled or boundary cycle that changes them. `unclean_halt` appears one edge after the edge on which Run falls. `stopped` follows `power_ok` at once. Inputs are driven on falling edges, and every check samples on a falling edge after the number of rising edges counted for that result. Steps are checked by counting enabled cycles over a window long enough to hold any instruction, and the window runs past the expected halt so that an extra instruction is also caught.

// File: rtl/runstop_pkg.sv
package runstop_pkg;
    localparam int PH_W = 4;

    typedef struct packed {
        logic            stop;
        logic [PH_W-1:0] phase;
        logic [PH_W-1:0] len;
        logic            att;
        logic            run_prev;
        logic            unclean;
    } rs_state_t;
endpackage

// File: rtl/runstop_sync.sv
module runstop_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout,
    output logic any_high
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign dout     = chain_q[STAGES-1];
    assign any_high = |chain_q;
endmodule

// File: rtl/runstop_ctrl.sv
module runstop_ctrl
    import runstop_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_run,
    input  logic            set_ss,
    input  logic            clr_stop,
    input  logic            half_step,
    input  logic            err,
    input  logic            power_ok,
    input  logic [PH_W-1:0] instr_len,
    output logic            clk_en,
    output logic            stopped,
    output logic            unclean_halt,
    output logic            half_mode,
    output logic [PH_W-1:0] phase
);
    localparam logic [PH_W-1:0] HALF_LEN = PH_W'(2);

    rs_state_t st_q, st_d;
    logic run, run_any;

    // R2: level synchroniser for the run request
    runstop_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (set_run),
        .dout     (run),
        .any_high (run_any)
    );

    logic [PH_W-1:0] cur_len;
    logic            at_t0, last_ph, half_pt, en, stop_set, stop_clr;

    always_comb begin
        st_d     = st_q;
        at_t0    = (st_q.phase == '0);
        cur_len  = at_t0 ? instr_len : st_q.len;
        last_ph  = ({1'b0, st_q.phase} + 1'b1) >= {1'b0, cur_len};
        half_pt  = st_q.att && at_t0 && (cur_len == HALF_LEN);
        en       = run && !st_q.stop;
        stop_set = (en && ((last_ph && (set_ss || err)) || (half_pt && set_ss)))
                   || !power_ok;
        stop_clr = clr_stop && !run_any;

        if (stop_set)      st_d.stop = 1'b1;
        else if (stop_clr) st_d.stop = 1'b0;

        if (en) begin
            st_d.phase = last_ph ? '0 : st_q.phase + 1'b1;
            if (at_t0) st_d.len = instr_len;
        end

        if (at_t0) st_d.att = half_step;

        st_d.run_prev = run;
        if (run && !st_q.run_prev)
            st_d.unclean = 1'b0;
        else if (!run && st_q.run_prev && !st_q.stop && !at_t0)
            st_d.unclean = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign clk_en       = en;
    assign stopped      = st_q.stop || !power_ok;
    assign unclean_halt = st_q.unclean;
    assign half_mode    = st_q.att;
    assign phase        = st_q.phase;
endmodule

// File: rtl/runstop_ctrl_chk.sv
module runstop_ctrl_chk
    import runstop_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            clr_stop,
    input logic            power_ok,
    input logic            clk_en,
    input logic            stopped,
    input logic            unclean_halt,
    input logic            half_mode,
    input logic [PH_W-1:0] phase
);
    // R6
    stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && !clr_stop) |=> stopped);

    // R4
    halt_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stopped) && power_ok && $past(power_ok))
            |-> (phase == '0 || (half_mode && phase == PH_W'(1))));

    // R3
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(phase));

    // R10
    power_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !power_ok |=> !clk_en);

    // R11
    unclean_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unclean_halt) |-> (!clk_en && phase != '0));
endmodule

bind runstop_ctrl runstop_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_stop     (clr_stop),
    .power_ok     (power_ok),
    .clk_en       (clk_en),
    .stopped      (stopped),
    .unclean_halt (unclean_halt),
    .half_mode    (half_mode),
    .phase        (phase)
);

// File: tb/tb_runstop_ctrl.sv
module tb_runstop_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       set_run = 0, set_ss = 0, clr_stop = 0, half_step = 0, err = 0, power_ok = 1;
    logic [3:0] instr_len = 4'd2;
    logic       clk_en, stopped, unclean_halt, half_mode;
    logic [3:0] phase;

    int n_checks = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    runstop_ctrl dut (
        .clk(clk), .rst_n(rst_n), .set_run(set_run), .set_ss(set_ss),
        .clr_stop(clr_stop), .half_step(half_step), .err(err),
        .power_ok(power_ok), .instr_len(instr_len), .clk_en(clk_en),
        .stopped(stopped), .unclean_halt(unclean_halt),
        .half_mode(half_mode), .phase(phase)
    );

    // step vectors: {len[3:0], half, err, exp_cycles[3:0], exp_phase[3:0]}
    localparam int NV = 8;
    localparam logic [13:0] VEC [NV] = '{
        {4'd2, 1'b0, 1'b0, 4'd2, 4'd0},
        {4'd3, 1'b0, 1'b0, 4'd3, 4'd0},
        {4'd5, 1'b0, 1'b1, 4'd5, 4'd0},
        {4'd2, 1'b1, 1'b0, 4'd1, 4'd1},
        {4'd2, 1'b1, 1'b0, 4'd1, 4'd0},
        {4'd4, 1'b1, 1'b0, 4'd4, 4'd0},
        {4'd8, 1'b0, 1'b0, 4'd8, 4'd0},
        {4'd1, 1'b0, 1'b0, 4'd1, 4'd0}
    };

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drop run, clear stop in a later write, then step one instruction
    task automatic do_step(input logic [3:0] len, input logic hs, input logic e,
                           output int cnt);
        set_run = 0; set_ss = 0;
        tick(3);
        clr_stop = 1;
        tick(1);
        clr_stop = 0; half_step = hs; instr_len = len; err = e;
        tick(1);
        set_run = 1; set_ss = 1;
        cnt = 0;
        for (int k = 0; k < 20; k++) begin
            tick(1);
            if (clk_en) cnt++;
        end
    endtask

    initial begin
        int cnt;
        logic [3:0] prev;
        logic [13:0] v;
        tick(2);
        // R1 reset state
        check("R1 clk_en", clk_en, 0);
        check("R1 stopped", stopped, 0);
        check("R1 unclean", unclean_halt, 0);
        check("R1 phase", phase, 0);
        rst_n = 1;
        tick(1);

        // R2 synchroniser latency
        instr_len = 4'd3;
        set_run = 1;
        tick(1);
        check("R2 en after 1 edge", clk_en, 0);
        tick(1);
        check("R2 en after 2 edges", clk_en, 1);

        // R3 free run
        prev = phase;
        for (int k = 0; k < 12; k++) begin
            tick(1);
            check("R3 enable held", clk_en, 1);
            check("R3 phase order", phase, (prev == 4'd2) ? 0 : prev + 1);
            prev = phase;
        end

        // R4 clean halt on step request
        set_ss = 1;
        tick(6);
        check("R4 stopped", stopped, 1);
        check("R4 halt phase", phase, 0);
        check("R4 en low", clk_en, 0);

        // R6 clr_stop while set_run high is ignored
        clr_stop = 1; tick(1); clr_stop = 0; tick(4);
        check("R6 clr with run high", stopped, 1);
        // R6 clr_stop in same write as dropping run is ignored
        set_run = 0; set_ss = 0; clr_stop = 1; tick(1); clr_stop = 0; tick(4);
        check("R6 clr same write", stopped, 1);
        // R6 clr_stop in a later write is accepted
        clr_stop = 1; tick(1); clr_stop = 0;
        check("R6 clr later write", stopped, 0);

        // R9 error halts free running at a boundary
        instr_len = 4'd3; set_run = 1;
        tick(7);
        err = 1;
        tick(6);
        check("R9 err halts", stopped, 1);
        check("R9 err boundary", phase, 0);
        err = 0;

        // vector table: R5 single step, R7 half step, R9 err step
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            do_step(v[13:10], v[9], v[8], cnt);
            check($sformatf("R5/R7 step cycles vec %0d", i), cnt, v[7:4]);
            check($sformatf("R5/R7 step phase vec %0d", i), phase, v[3:0]);
            check($sformatf("R5 stays stopped vec %0d", i), stopped, 1);
            err = 0;
        end

        // R8 half_step held mid-instruction
        do_step(4'd2, 1'b1, 1'b0, cnt);
        check("R7 half stop phase", phase, 1);
        half_step = 0;
        tick(2);
        check("R8 mode held mid-instr", half_mode, 1);
        do_step(4'd2, 1'b0, 1'b0, cnt);
        check("R7 second half cycles", cnt, 1);
        tick(1);
        check("R8 mode updated at t0", half_mode, 0);

        // R11 unclean halt
        set_run = 0; set_ss = 0; tick(3);
        clr_stop = 1; tick(1); clr_stop = 0;
        instr_len = 4'd5; set_run = 1;
        for (int k = 0; k < 20 && phase != 4'd2; k++) tick(1);
        set_run = 0;
        tick(5);
        check("R11 unclean set", unclean_halt, 1);
        check("R11 not stopped", stopped, 0);
        check("R11 en low", clk_en, 0);
        set_run = 1;
        tick(4);
        check("R11 unclean cleared", unclean_halt, 0);

        // R10 power loss
        power_ok = 0;
        #1;
        check("R10 stopped immediate", stopped, 1);
        tick(1);
        check("R10 en low", clk_en, 0);
        power_ok = 1;
        tick(3);
        check("R10 stop kept", stopped, 1);
        check("R10 en kept low", clk_en, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule